// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one history register for all branches. The register holds the most recent resolved outcomes, one bit each, and records a taken branch as 1. The block also keeps a table of 2-bit saturating counters. The fetch port combines the word address of the branch with the history register using XOR, reads the counter at that slot, and returns the counter's upper bit as the prediction in the same cycle. The fetch port also returns the history value it used.

The execute stage later sends that history snapshot back with the branch address and the real outcome. The block uses the snapshot to rebuild the same slot, moves that counter one step toward the outcome, and shifts the outcome into the history register. Because the slot depends on recent outcomes as well as on the address, one branch can use different counters for different history contexts. This lets the table learn repeating patterns, such as the exit of an inner loop.

Top module: `ghist_xor_predictor`

## Requirements
- R1: After a synchronous active-low reset, the history register reads 0 and every counter holds 01. Every address is therefore predicted not-taken.
- R2: The table slot is the address bits [IDX_W+1:2] XORed with the history zero-extended to IDX_W bits. Address bits [1:0] and the bits above IDX_W+1 have no effect on the slot.
- R3: `pred_taken` is the upper bit of the counter at the fetch slot. It is valid in the same cycle as `fetch_pc`.
- R4: A resolve with `res_taken`=1 adds one to the counter at the resolve slot. A counter at 3 stays at 3.
- R5: A resolve with `res_taken`=0 subtracts one from the counter at the resolve slot. A counter at 0 stays at 0.
- R6: The resolve slot is built from `res_pc` and `res_hist`. The current history register is not used for it.
- R7: Each resolve shifts `res_taken` into bit 0 of the history register, and the older bits move up one place. The register does not change in a cycle without a resolve. All branches share this one register.
- R8: `pred_hist` always shows the current history register.
- R9: When a resolve and a fetch happen in the same cycle, the prediction uses the table and history as they were before that resolve.
- R10: With a 3-bit history, a branch whose outcomes repeat 1,1,1,0 is predicted correctly on every occurrence once it has run through the pattern four times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History snapshot used for this prediction |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_hist | input | HIST_W | History snapshot returned with the earlier prediction |

## Verification
The hardest cases to reach from the ports are the counters at saturation and the counters trained under a stale history snapshot. The fetch slot always moves with the live history, so a test cannot simply read a chosen counter back. To reach a chosen counter, the bench calculates a fetch address whose bits, XORed with the live history, land on that slot. It then drives repeated resolves with a fixed snapshot to push the counter into saturation at both 3 and 0. Random traffic over a small set of addresses sends back snapshots that do not match the live history and overlaps fetch with resolve in the same cycle. A reference model in the bench predicts every output.

// File: rtl/bpred_pkg.sv
// Package: types and counter arithmetic shared by the predictor modules.
// Assumes: counters are 2 bits wide and the upper bit is the direction.
package bpred_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_STRONG_NT = 2'b00;
    localparam ctr2_t CTR_WEAK_NT   = 2'b01;
    localparam ctr2_t CTR_STRONG_T  = 2'b11;

    // Move a counter one step toward the outcome, saturating at both ends.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        if (taken)
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_history_reg.sv
// Module: global outcome history register.
// Shifts one outcome bit in at bit 0 on each enable. Synchronous
// active-low reset clears it. Assumes HIST_W >= 1.
module bp_history_reg #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_next;

    // Build the shifted value; a 1-bit history simply takes the new bit.
    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_next = shift_bit;
        end else begin : g_multi
            always_comb hist_next = {hist[HIST_W-2:0], shift_bit};
        end
    endgenerate

    // Register the history; hold when no outcome arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= hist_next;
    end

    generate
        if (HIST_W > 1) begin : g_chk
            AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> (hist[0] == $past(shift_bit)) &&
                             (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]))); // R7
        end
    endgenerate

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist)); // R7

endmodule

// File: rtl/bp_index_hash.sv
// Module: builds a table slot from a word address and a history value.
// Drops address bits [1:0] and XORs bits [IDX_W+1:2] with the history,
// which is zero-extended when it is narrower than the slot.
// Assumes HIST_W <= IDX_W and PC_W >= IDX_W + 2.
module bp_index_hash #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int PAD_W = IDX_W - HIST_W;

    logic [IDX_W-1:0] hist_ext;

    // Widen the history to the slot width.
    generate
        if (PAD_W == 0) begin : g_same
            always_comb hist_ext = hist;
        end else begin : g_pad
            always_comb hist_ext = {{PAD_W{1'b0}}, hist};
        end
    endgenerate

    // Combine word address and history.
    always_comb idx = pc[IDX_W+1:2] ^ hist_ext;

endmodule

// File: rtl/bp_counter_table.sv
// Module: table of 2-bit saturating counters.
// Has one combinational read port and one clocked update port. A read
// in the cycle of an update sees the old contents. Synchronous
// active-low reset sets every entry to weakly not-taken.
module bp_counter_table
    import bpred_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output ctr2_t            look_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr2_t            tbl [DEPTH];
    ctr2_t            upd_cur;
    logic [IDX_W-1:0] chk_idx;

    // Read the prediction counter from stored state.
    always_comb look_ctr = tbl[look_idx];

    // Read the counter that is about to be trained.
    always_comb upd_cur = tbl[upd_idx];

    // Reset all entries, or step the addressed entry toward the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                tbl[i] <= CTR_WEAK_NT;
        end else if (upd_en) begin
            tbl[upd_idx] <= ctr_step(upd_cur, upd_taken);
        end
    end

    // Remember the last update slot for the checks below.
    always_ff @(posedge clk) begin
        chk_idx <= upd_idx;
    end

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_cur != CTR_STRONG_T)
        |=> tbl[chk_idx] == $past(upd_cur) + 2'd1); // R4
    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_cur == CTR_STRONG_T)
        |=> tbl[chk_idx] == CTR_STRONG_T); // R4
    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && upd_cur != CTR_STRONG_NT)
        |=> tbl[chk_idx] == $past(upd_cur) - 2'd1); // R5
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && upd_cur == CTR_STRONG_NT)
        |=> tbl[chk_idx] == CTR_STRONG_NT); // R5

endmodule

// File: rtl/ghist_xor_predictor.sv
// Module: top of the global-history XOR-indexed direction predictor.
// Fetch: slot = address XOR live history, and the prediction is the
// upper bit of that counter, given in the same cycle. Resolve: slot =
// address XOR the returned snapshot; that counter is trained and the
// outcome is shifted into the history. Assumes word-aligned addresses.
module ghist_xor_predictor
    import bpred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_hist
);

    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  fetch_idx;
    logic [IDX_W-1:0]  res_idx;
    ctr2_t             fetch_ctr;

    bp_history_reg #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist      (ghist)
    );

    bp_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_fetch_hash (
        .pc   (fetch_pc),
        .hist (ghist),
        .idx  (fetch_idx)
    );

    bp_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_res_hash (
        .pc   (res_pc),
        .hist (res_hist),
        .idx  (res_idx)
    );

    bp_counter_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (fetch_idx),
        .look_ctr  (fetch_ctr),
        .upd_en    (res_valid),
        .upd_idx   (res_idx),
        .upd_taken (res_taken)
    );

    // Drive the prediction and its history snapshot.
    always_comb begin
        pred_taken = fetch_ctr[1];
        pred_hist  = ghist;
    end

endmodule

// File: tb/ghist_xor_predictor_bench.sv
// Bench: a reference model of counters and history, with directed cases
// and seeded random traffic.
module ghist_xor_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 32;
    localparam int HIST_W = 3;
    localparam int IDX_W  = 6;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   fetch_pc = '0;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              res_valid = 1'b0;
    logic [PC_W-1:0]   res_pc = '0;
    logic              res_taken = 1'b0;
    logic [HIST_W-1:0] res_hist = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [1:0]        m_ctr [DEPTH];
    logic [HIST_W-1:0] m_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    ghist_xor_predictor #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_ghist_xor_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_hist(res_hist)
    );

    function automatic logic [IDX_W-1:0] m_idx(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        return pc[IDX_W+1:2] ^ IDX_W'(h);
    endfunction

    // Fetch address that lands on a chosen slot under the model history.
    function automatic logic [PC_W-1:0] pc_for(input logic [IDX_W-1:0] slot, input logic [PC_W-1:0] junk);
        logic [PC_W-1:0] p;
        p = junk;
        p[IDX_W+1:2] = slot ^ IDX_W'(m_hist);
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; res_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b01;
        m_hist = '0;
    endtask

    // One cycle: fetch, optional resolve, compare before the edge, update model.
    task automatic step(input logic [PC_W-1:0] fpc, input logic rv, input logic [PC_W-1:0] rpc,
                        input logic rt, input logic [HIST_W-1:0] rh, input string tag,
                        output logic got);
        logic [IDX_W-1:0] k;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_hist = rh;
        #1;
        check(tag, pred_taken, m_ctr[m_idx(fpc, m_hist)][1]);
        check("R8 snapshot", pred_hist, m_hist);
        got = pred_taken;
        @(posedge clk);
        if (rv) begin
            k = m_idx(rpc, rh);
            if (rt) m_ctr[k] = (m_ctr[k] == 2'b11) ? 2'b11 : m_ctr[k] + 2'd1;
            else    m_ctr[k] = (m_ctr[k] == 2'b00) ? 2'b00 : m_ctr[k] - 2'd1;
            m_hist = {m_hist[HIST_W-2:0], rt};
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic g;
        int miss;
        logic [3:0] pat;
        void'($urandom(32'd2024));
        do_reset();

        // R1: every slot predicts not-taken, history zero
        for (int i = 0; i < DEPTH; i++)
            step(PC_W'(i) << 2, 1'b0, '0, 1'b0, '0, "R1 reset not-taken", g);
        check("R1 history zero", pred_hist, '0);

        // R10: repeating 1,1,1,0 loop branch, learned within four passes
        pat = 4'b1110;
        miss = 0;
        for (int it = 0; it < 32; it++) begin
            logic act;
            act = pat[3 - (it % 4)];
            step(32'h0000_0120, 1'b1, 32'h0000_0120, act, m_hist, "R9 R10 loop", g);
            if (it >= 16 && g != act) miss++;
        end
        check("R10 loop mispredicts after learning", miss, 0);

        do_reset();
        // R4: saturate slot 5 upward with snapshot 0, watch it via its fetch alias
        for (int n = 0; n < 5; n++)
            step(pc_for(6'd5, 32'hABC0_0003), 1'b1, 32'h0000_0014, 1'b1, '0, "R4 increment/saturate", g);
        step(pc_for(6'd5, 32'h0000_0001), 1'b0, '0, 1'b0, '0, "R4 saturated taken", g);
        check("R4 saturated reads taken", g, 1'b1);
        // R5: walk it down past zero
        for (int n = 0; n < 5; n++)
            step(pc_for(6'd5, 32'h5500_0002), 1'b1, 32'h0000_0014, 1'b0, '0, "R5 decrement/saturate", g);
        step(pc_for(6'd5, '0), 1'b1, 32'h0000_0014, 1'b1, '0, "R5 one up from zero", g);
        step(pc_for(6'd5, '0), 1'b0, '0, 1'b0, '0, "R5 still not-taken", g);
        check("R5 floor held", g, 1'b0);
        // R6: train with a stale snapshot 7 at pc 0 -> slot 7
        for (int n = 0; n < 2; n++)
            step(pc_for(6'd1, '0), 1'b1, 32'h0000_0000, 1'b1, 3'd7, "R6 stale snapshot", g);
        step(pc_for(6'd7, '0), 1'b0, '0, 1'b0, '0, "R6 snapshot slot", g);
        check("R6 snapshot slot trained", g, 1'b1);
        // R7: history holds with no resolve, then shifts
        step(32'h40, 1'b0, '0, 1'b0, '0, "R7 hold", g);
        step(32'h40, 1'b0, '0, 1'b0, '0, "R7 hold", g);
        step(32'h40, 1'b1, 32'h80, 1'b1, 3'd2, "R7 shift", g);
        step(32'h40, 1'b0, '0, 1'b0, '0, "R7 after shift", g);

        // Random traffic: few addresses, random junk bits (R2), stale snapshots (R6), overlap (R9)
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] fp, rp;
            logic [HIST_W-1:0] rh;
            fp = {$urandom} & 32'hFFFF_FF03;
            fp[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
            rp = {$urandom} & 32'hFFFF_FF03;
            rp[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
            rh = ($urandom_range(0, 3) == 0) ? HIST_W'($urandom) : m_hist;
            step(fp, $urandom_range(0, 3) != 0, rp, $urandom_range(0, 2) != 0, rh,
                 "R2 R3 R6 R9 random", g);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule